// File: doc/BRIEF.md
# Power-On Bring-Up Sequencer

This controller runs once after power-on reset and leads the chip through a fixed chain of five bring-up steps. Each step is started by a one-cycle pulse on its own bit of `step_start`. An outside agent then finishes the step with `step_done`, and `step_fail` is sampled alongside it as the verdict. The five steps, in order, are: start the system monitor and the boot clock, clear the management and configuration-unit RAMs, check that the boot clock has locked, check the low-power, auxiliary and I/O supply ranges, and clear the low-power and full-power domains.

If every step passes, the controller releases the active-low reset of the downstream configuration unit and enters a service state. At the same clock edge it latches the boot-mode pins and reports one of two boot classes: boot from a stored image, or boot with control handed to a debug host. A failing verdict or an expired per-step timeout sends the controller to a sticky error state. The error state keeps the downstream reset asserted and reports which step failed and whether a timeout caused it.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst_n` is low, `step_start` is all zero, `cfg_rst_n` is 0, and `in_service`, `in_error`, `boot_from_image` and `boot_from_debug` are all 0.
- R2: Steps are issued in the order 0 to 4. Bit 0 is monitor/clock start, bit 1 is RAM clear, bit 2 is clock-lock check, bit 3 is supply check and bit 4 is domain clear. Each issue is a one-cycle, one-hot pulse on `step_start`. Step 0 is issued in the second cycle after reset release, and step i+1 is issued in the cycle after step i's passing `step_done` is sampled.
- R3: When `step_done` is sampled with `step_fail`=1 while a step is awaited, the controller enters error in the next cycle. It then shows `err_step` equal to that step's index and `err_timeout`=0, and issues no further steps.
- R4: With a nonzero `timeout_limit` N, a step that gets no `step_done` in its N waiting cycles causes error in the following cycle, with `err_timeout`=1 and `err_step` equal to that step's index. A `step_done` that arrives in the last waiting cycle still counts.
- R5: A `timeout_limit` of 0 disables the timeout, so a step may take any number of cycles.
- R6: `cfg_rst_n` is 0 in every state before service. It goes to 1, together with `in_service`, in the cycle after step 4's passing `step_done` is sampled.
- R7: Error is sticky until `rst_n`. While in error, `cfg_rst_n` stays 0, `step_start` stays 0, and `step_done`/`step_fail` have no effect.
- R8: `boot_mode` captures `boot_pins` at the clock edge that enters service. After that it holds the captured value whatever the pins do, until the next reset.
- R9: In service, `boot_from_debug` is 1 exactly when the latched code equals `DEBUG_CODE` (default 0), and `boot_from_image` is 1 otherwise. Outside service, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| timeout_limit | input | TO_W | Waiting cycles allowed per step; 0 disables the timeout |
| step_done | input | 1 | Agent reports the current step finished |
| step_fail | input | 1 | Verdict sampled with `step_done`; 1 means failure |
| boot_pins | input | PIN_W | External boot-mode pins |
| step_start | output | 5 | One-cycle, one-hot start pulse per step |
| cfg_rst_n | output | 1 | Active-low reset of the downstream configuration unit |
| in_service | output | 1 | Sequence completed; service state |
| in_error | output | 1 | Sticky failure state |
| err_step | output | 3 | Index of the failing step |
| err_timeout | output | 1 | Failure was caused by timeout |
| boot_mode | output | PIN_W | Latched boot-mode code |
| boot_from_image | output | 1 | Boot class: stored image |
| boot_from_debug | output | 1 | Boot class: debug host |

## Verification
The table cases cover a clean pass with a non-debug pin code and a clean pass with the debug code at a longer agent latency, which separates the two boot classes and shows the order is independent of latency. They also cover a failing verdict at the first and at the last step, which checks that the failing index is reported at both ends of the chain. Two further cases exercise a silent agent, one of them combining a timeout with a later failing verdict, which shows that the earliest fault wins and that timeouts are flagged apart from verdict failures. Directed cases then check the reset state, a slow agent with the timeout disabled, pins changing after service, and done pulses arriving while the controller sits in error.

// File: rtl/boot_seq_pkg.sv
// Package: shared constants and state encoding for the bring-up sequencer.
// Assumes a fixed five-step chain; step indices are the bit positions of step_start.
package boot_seq_pkg;
    localparam int NUM_STEPS = 5;
    localparam int STEP_W    = $clog2(NUM_STEPS);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ISSUE   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_SERVICE = 3'd3,
        ST_ERROR   = 3'd4
    } seq_state_t;
endpackage

// File: rtl/step_timer.sv
// Module: per-step timeout counter.
// Counts waiting cycles of the current step; cleared when a step is issued.
// Assumes limit is stable during a step; limit==0 never expires.
module step_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    // Count waiting cycles, restart on each new step.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clear)  cnt <= '0;
        else if (run)    cnt <= cnt + 1'b1;
    end

    // Expire in the last allowed waiting cycle.
    always_comb begin
        expired = run && (limit != '0) && (cnt == limit - 1'b1);
    end
endmodule

// File: rtl/boot_mode_latch.sv
// Module: boot-mode capture and classification.
// Captures the pins once on the capture strobe and holds them until reset.
// Assumes capture pulses at most once per reset period.
module boot_mode_latch #(
    parameter int                 PIN_W      = 3,
    parameter logic [PIN_W-1:0]   DEBUG_CODE = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [PIN_W-1:0] pins,
    output logic [PIN_W-1:0] mode,
    output logic             is_image,
    output logic             is_debug
);
    logic valid;

    // Latch the pin code and mark it valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            valid <= 1'b0;
        end else if (capture && !valid) begin
            mode  <= pins;
            valid <= 1'b1;
        end
    end

    // Classify the latched code; nothing is reported before capture.
    always_comb begin
        is_debug = valid && (mode == DEBUG_CODE);
        is_image = valid && (mode != DEBUG_CODE);
    end
endmodule

// File: rtl/boot_seq_fsm.sv
// Module: step-chain state machine.
// Issues each step with a one-hot pulse, waits for done, and moves on, stops
// in error, or releases the downstream reset after the last step.
// Assumes step_fail is meaningful only together with step_done.
module boot_seq_fsm
    import boot_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 step_done,
    input  logic                 step_fail,
    input  logic                 expired,
    output logic [NUM_STEPS-1:0] step_start,
    output logic                 waiting,
    output logic                 issuing,
    output logic                 enter_service,
    output logic                 in_service,
    output logic                 in_error,
    output logic [STEP_W-1:0]    err_step,
    output logic                 err_timeout,
    output logic                 cfg_rst_n
);
    seq_state_t        state;
    logic [STEP_W-1:0] idx;

    // Sequence control; SERVICE and ERROR are terminal until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            idx         <= '0;
            err_step    <= '0;
            err_timeout <= 1'b0;
            cfg_rst_n   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE:  state <= ST_ISSUE;
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (step_done) begin
                        if (step_fail) begin
                            state    <= ST_ERROR;
                            err_step <= idx;
                        end else if (idx == LAST_STEP) begin
                            state     <= ST_SERVICE;
                            cfg_rst_n <= 1'b1;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= ST_ISSUE;
                        end
                    end else if (expired) begin
                        state       <= ST_ERROR;
                        err_step    <= idx;
                        err_timeout <= 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // One start bit per step, decoded from the issue state and step index.
    for (genvar gi = 0; gi < NUM_STEPS; gi++) begin : g_start
        assign step_start[gi] = (state == ST_ISSUE) && (idx == STEP_W'(gi));
    end

    // State flags for the timer, mode latch and outputs.
    always_comb begin
        issuing       = (state == ST_ISSUE);
        waiting       = (state == ST_WAIT);
        enter_service = waiting && step_done && !step_fail && (idx == LAST_STEP);
        in_service    = (state == ST_SERVICE);
        in_error      = (state == ST_ERROR);
    end
endmodule

// File: rtl/boot_seq_top.sv
// Module: bring-up sequencer top.
// Joins the step state machine, the per-step timeout and the boot-mode latch.
// Assumes rst_n is the power-on reset, synchronous to clk.
module boot_seq_top
    import boot_seq_pkg::*;
#(
    parameter int               TO_W       = 16,
    parameter int               PIN_W      = 3,
    parameter logic [PIN_W-1:0] DEBUG_CODE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TO_W-1:0]      timeout_limit,
    input  logic                 step_done,
    input  logic                 step_fail,
    input  logic [PIN_W-1:0]     boot_pins,
    output logic [NUM_STEPS-1:0] step_start,
    output logic                 cfg_rst_n,
    output logic                 in_service,
    output logic                 in_error,
    output logic [STEP_W-1:0]    err_step,
    output logic                 err_timeout,
    output logic [PIN_W-1:0]     boot_mode,
    output logic                 boot_from_image,
    output logic                 boot_from_debug
);
    logic seq_waiting;
    logic seq_issuing;
    logic seq_expired;
    logic seq_enter_service;

    step_timer #(.TO_W(TO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (seq_issuing),
        .run     (seq_waiting),
        .limit   (timeout_limit),
        .expired (seq_expired)
    );

    boot_seq_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .step_done     (step_done),
        .step_fail     (step_fail),
        .expired       (seq_expired),
        .step_start    (step_start),
        .waiting       (seq_waiting),
        .issuing       (seq_issuing),
        .enter_service (seq_enter_service),
        .in_service    (in_service),
        .in_error      (in_error),
        .err_step      (err_step),
        .err_timeout   (err_timeout),
        .cfg_rst_n     (cfg_rst_n)
    );

    boot_mode_latch #(.PIN_W(PIN_W), .DEBUG_CODE(DEBUG_CODE)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (seq_enter_service),
        .pins     (boot_pins),
        .mode     (boot_mode),
        .is_image (boot_from_image),
        .is_debug (boot_from_debug)
    );
endmodule

// File: rtl/boot_seq_chk.sv
// Module: property checker for the bring-up sequencer, bound to the top.
module boot_seq_chk
    import boot_seq_pkg::*;
#(
    parameter int PIN_W = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 step_done,
    input logic                 step_fail,
    input logic [NUM_STEPS-1:0] step_start,
    input logic                 cfg_rst_n,
    input logic                 in_service,
    input logic                 in_error,
    input logic [STEP_W-1:0]    err_step,
    input logic                 err_timeout,
    input logic [PIN_W-1:0]     boot_mode,
    input logic                 boot_from_image,
    input logic                 boot_from_debug,
    input logic                 waiting
);
    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_start)); // R2
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_start != '0) |=> (step_start == '0)); // R2
    AST_FAIL_TO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (waiting && step_done && step_fail) |=> (in_error && !err_timeout)); // R3
    AST_RESET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_service |-> !cfg_rst_n); // R6
    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        in_error |=> (in_error && $stable(err_step) && !cfg_rst_n && step_start == '0)); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_service |=> (in_service && $stable(boot_mode))); // R8
    AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_from_image || boot_from_debug) == in_service
        && !(boot_from_image && boot_from_debug)); // R9
endmodule

bind boot_seq_top boot_seq_chk #(.PIN_W(PIN_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .step_done       (step_done),
    .step_fail       (step_fail),
    .step_start      (step_start),
    .cfg_rst_n       (cfg_rst_n),
    .in_service      (in_service),
    .in_error        (in_error),
    .err_step        (err_step),
    .err_timeout     (err_timeout),
    .boot_mode       (boot_mode),
    .boot_from_image (boot_from_image),
    .boot_from_debug (boot_from_debug),
    .waiting         (seq_waiting)
);

// File: tb/test_boot_seq_top.sv
module test_boot_seq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timeout_limit = 16'd8;
    logic        step_done = 1'b0;
    logic        step_fail = 1'b0;
    logic [2:0]  boot_pins = 3'd0;
    logic [4:0]  step_start;
    logic        cfg_rst_n, in_service, in_error, err_timeout;
    logic [2:0]  err_step, boot_mode;
    logic        boot_from_image, boot_from_debug;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;  // 50 MHz

    boot_seq_top i_boot_seq_top (
        .clk(clk), .rst_n(rst_n), .timeout_limit(timeout_limit),
        .step_done(step_done), .step_fail(step_fail), .boot_pins(boot_pins),
        .step_start(step_start), .cfg_rst_n(cfg_rst_n), .in_service(in_service),
        .in_error(in_error), .err_step(err_step), .err_timeout(err_timeout),
        .boot_mode(boot_mode), .boot_from_image(boot_from_image),
        .boot_from_debug(boot_from_debug)
    );

    typedef struct packed {
        logic [2:0] fail_s;   // 7 = no failing step
        logic [2:0] hang_s;   // 7 = no silent step
        logic [2:0] pins;
        logic [7:0] dly;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{3'd7, 3'd7, 3'b101, 8'd1},
        '{3'd7, 3'd7, 3'b000, 8'd3},
        '{3'd0, 3'd7, 3'b010, 8'd1},
        '{3'd4, 3'd7, 3'b011, 8'd2},
        '{3'd7, 3'd2, 3'b110, 8'd1},
        '{3'd3, 3'd1, 3'b001, 8'd2}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset(input logic [2:0] pins, input logic [15:0] lim);
        @(negedge clk);
        rst_n = 1'b0; step_done = 1'b0; step_fail = 1'b0;
        boot_pins = pins; timeout_limit = lim;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Plays the agent for one run and checks order, timeout and outcome.
    task automatic run_case(input logic [2:0] fail_s, input logic [2:0] hang_s,
                            input logic [2:0] pins, input int dly, input logic [15:0] lim);
        int  exp_idx = 0;
        bit  just = 0;
        int  first_bad;
        bit  exp_to;
        do_reset(pins, lim);
        first_bad = (fail_s < hang_s) ? fail_s : hang_s;
        exp_to    = (hang_s < fail_s);
        for (int cyc = 0; cyc < 3000; cyc++) begin
            if (!just) @(negedge clk);
            just = 0;
            if (in_service || in_error) break;
            if (cfg_rst_n !== 1'b0) chk(0, "R6 cfg_rst_n early", cfg_rst_n, 0);
            if (step_start != 5'd0) begin
                chk(step_start == (5'd1 << exp_idx), "R2 step order", step_start, 1 << exp_idx);
                if (exp_idx == hang_s) begin
                    for (int k = 1; k <= lim; k++) begin
                        @(negedge clk);
                        if (in_error) chk(0, "R4 timeout early", k, lim + 1);
                    end
                    @(negedge clk);
                    chk(in_error && err_timeout && err_step == hang_s, "R4 timeout",
                        {in_error, err_timeout, err_step}, {2'b11, hang_s});
                    break;
                end
                repeat (dly) @(negedge clk);
                step_done = 1'b1;
                step_fail = (exp_idx == fail_s);
                @(negedge clk);
                step_done = 1'b0;
                step_fail = 1'b0;
                exp_idx++;
                just = 1;
            end
        end
        if (first_bad == 7) begin
            chk(in_service && cfg_rst_n && !in_error, "R6 release",
                {in_service, cfg_rst_n, in_error}, 3'b110);
            chk(boot_mode == pins, "R8 mode capture", boot_mode, pins);
            chk(boot_from_debug == (pins == 3'd0) && boot_from_image == (pins != 3'd0),
                "R9 class", {boot_from_debug, boot_from_image}, {pins == 3'd0, pins != 3'd0});
        end else begin
            chk(in_error && !in_service && !cfg_rst_n, "R3 error state",
                {in_error, in_service, cfg_rst_n}, 3'b100);
            chk(err_step == first_bad && err_timeout == exp_to, "R3 error report",
                {err_timeout, err_step}, {exp_to, first_bad[2:0]});
            chk(!boot_from_image && !boot_from_debug, "R9 no class in error",
                {boot_from_image, boot_from_debug}, 0);
        end
    endtask

    initial begin
        // R1: reset state
        @(negedge clk); @(negedge clk);
        chk(step_start == 0 && !cfg_rst_n && !in_service && !in_error, "R1 reset outputs",
            {step_start, cfg_rst_n, in_service, in_error}, 0);
        chk(!boot_from_image && !boot_from_debug, "R1 reset class",
            {boot_from_image, boot_from_debug}, 0);

        for (int v = 0; v < 6; v++) begin
            run_case(VECS[v].fail_s, VECS[v].hang_s, VECS[v].pins, int'(VECS[v].dly), 16'd8);
            if (v == 0) begin
                // R8: pins move after service, code must hold
                boot_pins = 3'b010;
                repeat (3) @(negedge clk);
                chk(boot_mode == 3'b101 && boot_from_image, "R8 hold after service", boot_mode, 3'b101);
            end
            if (v == 2) begin
                // R7: done pulses in error have no effect
                step_done = 1'b1; step_fail = 1'b0;
                repeat (3) @(negedge clk);
                step_done = 1'b0;
                @(negedge clk);
                chk(in_error && !in_service && !cfg_rst_n && step_start == 0 && err_step == 0,
                    "R7 sticky error", {in_error, in_service, cfg_rst_n, err_step}, 6'b100000);
            end
        end

        // R5: timeout disabled, agent slow
        run_case(3'd7, 3'd7, 3'b001, 40, 16'd0);
        chk(in_service && !in_error, "R5 no timeout when limit is zero", in_service, 1);

        // R4 boundary: done in the last allowed waiting cycle still counts
        run_case(3'd7, 3'd7, 3'b100, 4, 16'd4);
        chk(in_service && !in_error, "R4 done at limit", in_service, 1);

        // R1: reset reasserted after service returns to reset state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk(!cfg_rst_n && !in_service && !boot_from_image && !boot_from_debug, "R1 re-reset",
            {cfg_rst_n, in_service, boot_from_image, boot_from_debug}, 0);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog R1 actual=%0h expected=%0h", 0, 1);
        finish_run();
    end
endmodule